// File: doc/BRIEF.md
# Radix-2 FFT Butterfly Index Scheduler

This block walks the three nested loops of an in-place radix-2 Cooley-Tukey FFT over N = 2^L elements and produces one butterfly per accepted output beat. For each butterfly it gives three indices: the lower data index, the upper data index (half a span above the lower one), and the twiddle coefficient index. The two data indices are multiplied by a configurable stride, so the same schedule can transform one column of a row-major 2D array in place. The coefficient index is never scaled.

A control unit sets log2 N, the stride and an output selector, then pulses `start`. The block checks the request, latches it, and presents butterflies on a ready/valid output until the last one is taken. Then it returns to idle and waits for the next start. A request that is malformed, or that would need more than 127 butterflies, is refused: the error flag is set and no beat is produced.

The controller has two states. In IDLE, a start with a good configuration moves it to RUN. A start with a bad configuration keeps it in IDLE and sets the error flag. In RUN, acceptance of the final butterfly moves it back to IDLE. Every other condition leaves the state unchanged.

Top module: `fft_bfly_sched`

## Requirements
- R1: After reset, `out_valid`, `done` and `err` are all low.
- R2: A `start` in IDLE with a good configuration raises `out_valid` on the next cycle. The first beat carries lower index 0, upper index equal to the stride, and coefficient 0.
- R3: The butterfly order follows three loops:
  - the outer loop takes span sizes 2, 4, … up to N, with half equal to size/2;
  - the middle loop takes block starts 0, size, 2·size, … below N;
  - the inner loop takes j from 0 to half−1.
  Each beat gives `out_lo` = (block+j)·stride and `out_hi` = (block+j+half)·stride.
- R4: `out_coef` equals j·(N/size) and is not multiplied by the stride.
- R5: `out_sel` follows the selector latched at start:
  - 2'b00 gives the scaled lower index;
  - 2'b01 gives the scaled upper index;
  - 2'b10 gives the coefficient, zero-extended;
  - 2'b11 gives zero.
- R6: While `out_valid` is high and `out_ready` is low, the beat is held: `out_valid` stays high and `out_lo`, `out_hi` and `out_coef` keep their values.
- R7: Exactly (N/2)·log2 N beats are produced. `done` is high only in the cycle the last beat is accepted (`out_valid` and `out_ready` both high). In the following cycle `out_valid` is low.
- R8: A start in IDLE is refused when any of these holds: `cfg_log2n` is 0, `cfg_stride` is 0, or (N/2)·log2 N exceeds 127 (that is, `cfg_log2n` of 6 or more). A refused start sets `err` from the next cycle and `out_valid` stays low. The next good start clears `err`.
- R9: `start` and changes on the configuration inputs during RUN have no effect. The running sequence continues unchanged and keeps the configuration latched at its start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_log2n | input | LOG2_W (3) | log2 of the transform size N |
| cfg_stride | input | STRIDE_W (3) | Multiplier applied to the data indices |
| cfg_sel | input | 2 | Selector for `out_sel` |
| start | input | 1 | Request a new schedule (used only in IDLE) |
| out_valid | output | 1 | A butterfly is presented |
| out_ready | input | 1 | Consumer takes the presented butterfly |
| out_lo | output | IDX_W (11) | Scaled lower data index |
| out_hi | output | IDX_W (11) | Scaled upper data index |
| out_coef | output | ADDR_W (8) | Twiddle coefficient index |
| out_sel | output | IDX_W (11) | Single index chosen by the latched selector |
| done | output | 1 | Last butterfly accepted this cycle |
| err | output | 1 | Most recent IDLE start was refused |

## Verification
The assertions check the following on every cycle:
- a stalled beat is held;
- the upper index always sits above the lower one;
- `done` appears only with an accepted beat and is followed by an idle cycle;
- a run cannot be cut short;
- an error never coexists with a valid beat;
- no run carries more than 127 beats.

The exact index sequence, the coefficient values, the selector mapping, the beat totals per size and the rejection cases are shown only by the bench. The bench compares every accepted beat against a schedule it builds from nested loops, under different sizes, strides, selectors and stall patterns.

// File: rtl/fft_sched_pkg.sv
package fft_sched_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sched_state_t;

    typedef enum logic [1:0] {
        SEL_LO   = 2'b00,
        SEL_HI   = 2'b01,
        SEL_COEF = 2'b10,
        SEL_NONE = 2'b11
    } sel_mode_t;
endpackage

// File: rtl/fft_cfg_check.sv
module fft_cfg_check #(
    parameter int LOG2_W   = 3,
    parameter int STRIDE_W = 3,
    parameter int MAX_OPS  = 127
) (
    input  logic [LOG2_W-1:0]   log2n,
    input  logic [STRIDE_W-1:0] stride,
    output logic                ok
);
    localparam int OPS_W = (1 << LOG2_W) + LOG2_W + 1;

    logic [OPS_W-1:0] ops;

    always_comb begin
        ops = '0;
        if (log2n != '0) begin
            ops = (OPS_W'(1) << (log2n - 1'b1)) * OPS_W'(log2n);
        end
        ok = (log2n != '0) && (stride != '0) && (ops <= OPS_W'(MAX_OPS));
    end
endmodule

// File: rtl/fft_loop_walker.sv
module fft_loop_walker #(
    parameter int LOG2_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic                      advance,
    input  logic [LOG2_W-1:0]         cfg_log2n,
    output logic [(1 << LOG2_W)-1:0]  lo_raw,
    output logic [(1 << LOG2_W)-1:0]  hi_raw,
    output logic [(1 << LOG2_W)-1:0]  coef,
    output logic                      last
);
    localparam int ADDR_W = 1 << LOG2_W;

    logic [LOG2_W-1:0] l_q;
    logic [LOG2_W-1:0] stage_q;
    logic [ADDR_W-1:0] blk_q;
    logic [ADDR_W-1:0] j_q;

    logic [ADDR_W-1:0] half;
    logic [ADDR_W-1:0] size;
    logic [ADDR_W-1:0] n_full;
    logic [ADDR_W-1:0] blk_next;
    logic              j_end;
    logic              b_end;
    logic              s_end;

    always_comb begin
        half     = ADDR_W'(1) << stage_q;
        size     = half << 1;
        n_full   = ADDR_W'(1) << l_q;
        blk_next = blk_q + size;
        j_end    = (j_q == half - 1'b1);
        b_end    = (blk_next == n_full);
        s_end    = (stage_q == l_q - 1'b1);
        last     = j_end && b_end && s_end;
        lo_raw   = blk_q + j_q;
        hi_raw   = blk_q + j_q + half;
        coef     = j_q << (l_q - 1'b1 - stage_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q     <= '0;
            stage_q <= '0;
            blk_q   <= '0;
            j_q     <= '0;
        end else if (load) begin
            l_q     <= cfg_log2n;
            stage_q <= '0;
            blk_q   <= '0;
            j_q     <= '0;
        end else if (advance) begin
            if (j_end) begin
                j_q <= '0;
                if (b_end) begin
                    blk_q   <= '0;
                    stage_q <= stage_q + 1'b1;
                end else begin
                    blk_q <= blk_next;
                end
            end else begin
                j_q <= j_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fft_idx_scale.sv
module fft_idx_scale #(
    parameter int ADDR_W   = 8,
    parameter int STRIDE_W = 3
) (
    input  logic [ADDR_W-1:0]          idx,
    input  logic [STRIDE_W-1:0]        stride,
    output logic [ADDR_W+STRIDE_W-1:0] scaled
);
    localparam int W = ADDR_W + STRIDE_W;

    assign scaled = W'(idx) * W'(stride);
endmodule

// File: rtl/fft_bfly_sched.sv
module fft_bfly_sched
    import fft_sched_pkg::*;
#(
    parameter int LOG2_W   = 3,
    parameter int STRIDE_W = 3,
    parameter int MAX_OPS  = 127,
    localparam int ADDR_W  = 1 << LOG2_W,
    localparam int IDX_W   = ADDR_W + STRIDE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LOG2_W-1:0]   cfg_log2n,
    input  logic [STRIDE_W-1:0] cfg_stride,
    input  logic [1:0]          cfg_sel,
    input  logic                start,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [IDX_W-1:0]    out_lo,
    output logic [IDX_W-1:0]    out_hi,
    output logic [ADDR_W-1:0]   out_coef,
    output logic [IDX_W-1:0]    out_sel,
    output logic                done,
    output logic                err
);
    sched_state_t state_q, state_d;

    logic                cfg_ok;
    logic                load;
    logic                advance;
    logic                last;
    logic [STRIDE_W-1:0] stride_q;
    sel_mode_t           sel_q;
    logic                err_q;
    logic [ADDR_W-1:0]   coef;
    logic [ADDR_W-1:0]   raw    [2];
    logic [IDX_W-1:0]    scaled [2];

    fft_cfg_check #(
        .LOG2_W  (LOG2_W),
        .STRIDE_W(STRIDE_W),
        .MAX_OPS (MAX_OPS)
    ) u_check (
        .log2n (cfg_log2n),
        .stride(cfg_stride),
        .ok    (cfg_ok)
    );

    fft_loop_walker #(
        .LOG2_W(LOG2_W)
    ) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .advance  (advance),
        .cfg_log2n(cfg_log2n),
        .lo_raw   (raw[0]),
        .hi_raw   (raw[1]),
        .coef     (coef),
        .last     (last)
    );

    for (genvar g = 0; g < 2; g++) begin : g_lane
        fft_idx_scale #(
            .ADDR_W  (ADDR_W),
            .STRIDE_W(STRIDE_W)
        ) u_scale (
            .idx   (raw[g]),
            .stride(stride_q),
            .scaled(scaled[g])
        );
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start && cfg_ok) state_d = ST_RUN;
            ST_RUN:  if (out_ready && last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and loop control
    always_comb begin
        out_valid = (state_q == ST_RUN);
        advance   = out_valid && out_ready;
        done      = advance && last;
        load      = (state_q == ST_IDLE) && start && cfg_ok;
        out_lo    = scaled[0];
        out_hi    = scaled[1];
        out_coef  = coef;
        err       = err_q;
        unique case (sel_q)
            SEL_LO:   out_sel = scaled[0];
            SEL_HI:   out_sel = scaled[1];
            SEL_COEF: out_sel = IDX_W'(coef);
            default:  out_sel = '0;
        endcase
    end

    // Latched configuration and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stride_q <= '0;
            sel_q    <= SEL_LO;
            err_q    <= 1'b0;
        end else if ((state_q == ST_IDLE) && start) begin
            err_q <= !cfg_ok;
            if (cfg_ok) begin
                stride_q <= cfg_stride;
                sel_q    <= sel_mode_t'(cfg_sel);
            end
        end
    end
endmodule

// File: rtl/fft_bfly_sched_chk.sv
module fft_bfly_sched_chk #(
    parameter int IDX_W   = 11,
    parameter int MAX_OPS = 127
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic             out_ready,
    input logic [IDX_W-1:0] out_lo,
    input logic [IDX_W-1:0] out_hi,
    input logic [7:0]       out_coef,
    input logic             done,
    input logic             err
);
    logic [15:0] beat_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_cnt <= '0;
        end else if (!out_valid) begin
            beat_cnt <= '0;
        end else if (out_ready) begin
            beat_cnt <= beat_cnt + 1'b1;
        end
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_lo) && $stable(out_hi) && $stable(out_coef)); // R6
    AST_HI_ABOVE_LO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_hi > out_lo); // R3
    AST_DONE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> out_valid && out_ready); // R7
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !out_valid); // R7
    AST_RUN_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !done |=> out_valid); // R9
    AST_ERR_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !out_valid); // R8
    AST_OPS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> beat_cnt < 16'(MAX_OPS)); // R8
endmodule

bind fft_bfly_sched fft_bfly_sched_chk #(
    .IDX_W  (IDX_W),
    .MAX_OPS(MAX_OPS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_lo   (out_lo),
    .out_hi   (out_hi),
    .out_coef (out_coef),
    .done     (done),
    .err      (err)
);

// File: tb/fft_bfly_sched_bench.sv
module fft_bfly_sched_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_log2n = '0;
    logic [2:0]  cfg_stride = '0;
    logic [1:0]  cfg_sel = '0;
    logic        start = 1'b0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [10:0] out_lo;
    logic [10:0] out_hi;
    logic [7:0]  out_coef;
    logic [10:0] out_sel;
    logic        done;
    logic        err;

    int checks = 0;
    int fails  = 0;

    int exp_lo   [128];
    int exp_hi   [128];
    int exp_coef [128];

    always #(CLK_PERIOD/2) clk = ~clk;

    fft_bfly_sched u_fft_bfly_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_log2n (cfg_log2n),
        .cfg_stride(cfg_stride),
        .cfg_sel   (cfg_sel),
        .start     (start),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_lo    (out_lo),
        .out_hi    (out_hi),
        .out_coef  (out_coef),
        .out_sel   (out_sel),
        .done      (done),
        .err       (err)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    function automatic int build_expected(input int l, input int s);
        int n = 1 << l;
        int cnt = 0;
        for (int st = 0; st < l; st++) begin
            int half = 1 << st;
            int size = half * 2;
            for (int b = 0; b < n; b += size) begin
                for (int j = 0; j < half; j++) begin
                    exp_lo[cnt]   = (b + j) * s;
                    exp_hi[cnt]   = (b + j + half) * s;
                    exp_coef[cnt] = j * (n / size);
                    cnt++;
                end
            end
        end
        return cnt;
    endfunction

    // One full schedule; stall_mode inserts ready gaps, poke tries to restart mid-run
    task automatic run_fft(input int l, input int s, input int sel, input bit stall_mode, input bit poke);
        int total;
        int beats = 0;
        int cyc = 0;
        bit stalled = 0;
        int held_lo = 0;
        int held_hi = 0;
        int held_coef = 0;
        int e_sel;
        total = build_expected(l, s);
        @(negedge clk);
        cfg_log2n  = 3'(l);
        cfg_stride = 3'(s);
        cfg_sel    = 2'(sel);
        start      = 1'b1;
        out_ready  = 1'b0;
        @(negedge clk);
        start = 1'b0;
        #1;
        check("R2", "valid after start", int'(out_valid), 1);
        check("R8", "err cleared by good start", int'(err), 0);
        while (beats < total && cyc < 2000) begin
            if (cyc != 0) @(negedge clk);
            if (poke && cyc == 3) begin
                start = 1'b1; cfg_log2n = 3'd1; cfg_stride = 3'd5; cfg_sel = 2'd3;
            end else if (poke && cyc == 4) begin
                start = 1'b0; cfg_log2n = 3'(l); cfg_stride = 3'(s); cfg_sel = 2'(sel);
            end
            out_ready = stall_mode ? (cyc % 3 != 1) : 1'b1;
            #1;
            if (stalled) begin
                check("R6", "held lo", int'(out_lo), held_lo);
                check("R6", "held hi", int'(out_hi), held_hi);
                check("R6", "held coef", int'(out_coef), held_coef);
                check("R6", "valid held", int'(out_valid), 1);
            end
            stalled = out_valid && !out_ready;
            held_lo = int'(out_lo); held_hi = int'(out_hi); held_coef = int'(out_coef);
            if (out_valid && out_ready) begin
                check(poke ? "R9" : "R3", "lo", int'(out_lo), exp_lo[beats]);
                check("R3", "hi", int'(out_hi), exp_hi[beats]);
                check("R4", "coef", int'(out_coef), exp_coef[beats]);
                case (sel)
                    0: e_sel = exp_lo[beats];
                    1: e_sel = exp_hi[beats];
                    2: e_sel = exp_coef[beats];
                    default: e_sel = 0;
                endcase
                check("R5", "sel output", int'(out_sel), e_sel);
                check("R7", "done", int'(done), (beats == total - 1) ? 1 : 0);
                beats++;
            end else begin
                check("R7", "no done without accept", int'(done), 0);
            end
            cyc++;
        end
        check("R7", "beat total", beats, (1 << (l - 1)) * l);
        @(negedge clk);
        out_ready = 1'b0;
        #1;
        check("R7", "valid low after done", int'(out_valid), 0);
    endtask

    task automatic test_reject(input int l, input int s);
        @(negedge clk);
        cfg_log2n  = 3'(l);
        cfg_stride = 3'(s);
        start      = 1'b1;
        out_ready  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        check("R8", "err on refused start", int'(err), 1);
        check("R8", "no valid on refused start", int'(out_valid), 0);
        @(negedge clk);
        #1;
        check("R8", "still idle", int'(out_valid), 0);
        out_ready = 1'b0;
    endtask

    task automatic test_reset();
        #1;
        check("R1", "valid at reset", int'(out_valid), 0);
        check("R1", "done at reset", int'(done), 0);
        check("R1", "err at reset", int'(err), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_fft(3, 1, 0, 1'b0, 1'b0);
        run_fft(2, 3, 1, 1'b1, 1'b0);
        run_fft(5, 2, 2, 1'b1, 1'b1);
        run_fft(1, 1, 3, 1'b0, 1'b0);
        test_reject(6, 1);
        test_reject(0, 1);
        test_reject(3, 0);
        run_fft(4, 7, 0, 1'b1, 1'b0);
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule